// File: doc/BRIEF.md
# Fast-Interrupt Source Routing Selector

This block picks exactly one of 72 raw, level-sensitive interrupt source lines and forwards it to a dedicated fast-interrupt output. The lines arrive in three groups: a primary group of 8 lines and two secondary groups of 32 lines each. A single control register, reached over a simple register bus, holds a 7-bit flat source number and an arm bit. The flat numbering puts the first secondary group first, the second secondary group next, and the primary group last.

The output is combinational from the register and the source lines. It tracks the chosen line's level in the same cycle and ignores any masking on the normal interrupt path. Software therefore has to mask a source on the normal path before it routes that source here. Otherwise both interrupt outputs assert together.

Top module: `fiq_route_sel`

## Requirements
- R1: After reset the control register reads 0 and `fiq_o` is low.
- R2: A bus write (`req_i` and `we_i` high at a clock edge) to byte address 0x0C stores `wdata_i[7:0]`. From the next cycle a read at 0x0C returns that byte, with bits 31:8 always zero. Bit 7 is the arm bit and bits 6:0 are the flat source number.
- R3: Writes to any other address leave the register unchanged, and reads at any address other than 0x0C return 0.
- R4: With the block armed, flat numbers 0 to 31 route `src_b1_i[n]` to `fiq_o`.
- R5: With the block armed, flat numbers 32 to 63 route `src_b2_i[n-32]` to `fiq_o`.
- R6: With the block armed, flat numbers 64 to 71 route `src_b0_i[n-64]` to `fiq_o`.
- R7: Flat numbers 72 to 127 select no line, and `fiq_o` stays low whatever the sources do.
- R8: With the arm bit clear, `fiq_o` is low for every source pattern.
- R9: `fiq_o` follows the selected line's level in the same cycle, with no register in that path. Only the unselected lines have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| src_b0_i | input | 8 | Primary group source levels |
| src_b1_i | input | 32 | First secondary group source levels |
| src_b2_i | input | 32 | Second secondary group source levels |
| fiq_o | output | 1 | Fast-interrupt output |

## Verification
The assertions assume that bus inputs are stable around each rising edge and that the source lines carry settled levels. The routing checks compare `fiq_o` against the line chosen by the stored number in the same cycle. The bench changes the bus and the sources only at falling edges. It samples `fiq_o` a short delay after each source change and reads registers half a cycle after the write edge. This way every compared value is settled.

// File: rtl/fiq_route_pkg.sv
package fiq_route_pkg;
  localparam int unsigned B0_W     = 8;
  localparam int unsigned B1_W     = 32;
  localparam int unsigned B2_W     = 32;
  localparam int unsigned NUM_SRC  = B1_W + B2_W + B0_W;
  localparam int unsigned IDX_W    = 7;
  localparam int unsigned IDX_SPAN = 2 ** IDX_W;
  localparam int unsigned CFG_W    = IDX_W + 1;

  typedef struct packed {
    logic             en;
    logic [IDX_W-1:0] idx;
  } fiq_cfg_t;
endpackage

// File: rtl/fiq_cfg_reg.sv
module fiq_cfg_reg
  import fiq_route_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CTRL_OFF = 'h0C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output fiq_cfg_t          cfg_o
);
  localparam int unsigned PAD_W = DATA_W - CFG_W;

  fiq_cfg_t cfg_q;
  logic     hit;

  assign hit = (addr_i == CTRL_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cfg_q <= '0;
    else if (req_i && we_i && hit) cfg_q <= fiq_cfg_t'(wdata_i[CFG_W-1:0]);
  end

  always_comb begin
    rdata_o = '0;
    if (hit) rdata_o = {{PAD_W{1'b0}}, cfg_q};
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/fiq_src_mux.sv
module fiq_src_mux
  import fiq_route_pkg::*;
(
  input  logic [B0_W-1:0] src_b0_i,
  input  logic [B1_W-1:0] src_b1_i,
  input  logic [B2_W-1:0] src_b2_i,
  input  fiq_cfg_t        cfg_i,
  output logic            fiq_o
);
  // flat order: group 1, group 2, group 0; tail padded with zeros
  logic [IDX_SPAN-1:0] flat;

  for (genvar g = 0; g < IDX_SPAN; g++) begin : g_flat
    if (g < B1_W) begin : g_b1
      assign flat[g] = src_b1_i[g];
    end else if (g < B1_W + B2_W) begin : g_b2
      assign flat[g] = src_b2_i[g-B1_W];
    end else if (g < NUM_SRC) begin : g_b0
      assign flat[g] = src_b0_i[g-B1_W-B2_W];
    end else begin : g_none
      assign flat[g] = 1'b0;
    end
  end

  assign fiq_o = cfg_i.en & flat[cfg_i.idx];
endmodule

// File: rtl/fiq_route_sel.sv
module fiq_route_sel
  import fiq_route_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [B0_W-1:0]   src_b0_i,
  input  logic [B1_W-1:0]   src_b1_i,
  input  logic [B2_W-1:0]   src_b2_i,
  output logic              fiq_o
);
  fiq_cfg_t cfg_q;

  fiq_cfg_reg #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CTRL_OFF(ADDR_W'('h0C))
  ) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .cfg_o  (cfg_q)
  );

  fiq_src_mux u_mux (
    .src_b0_i(src_b0_i),
    .src_b1_i(src_b1_i),
    .src_b2_i(src_b2_i),
    .cfg_i   (cfg_q),
    .fiq_o   (fiq_o)
  );
endmodule

// File: rtl/fiq_route_sel_chk.sv
module fiq_route_sel_chk
  import fiq_route_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [B0_W-1:0]   src_b0_i,
  input logic [B1_W-1:0]   src_b1_i,
  input logic [B2_W-1:0]   src_b2_i,
  input logic              fiq_o,
  input fiq_cfg_t          cfg_q
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'('h0C);

  AST_WRITE_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i == OFF |=> cfg_q == $past(wdata_i[CFG_W-1:0])); // R2
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:CFG_W] == '0); // R2
  AST_MISS_WRITE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i != OFF |=> $stable(cfg_q)); // R3
  AST_MISS_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i != OFF |-> rdata_o == '0); // R3
  AST_ROUTE_B1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.en && cfg_q.idx < 32 |-> fiq_o == src_b1_i[cfg_q.idx[4:0]]); // R4
  AST_ROUTE_B2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.en && cfg_q.idx >= 32 && cfg_q.idx < 64 |-> fiq_o == src_b2_i[cfg_q.idx[4:0]]); // R5
  AST_ROUTE_B0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.en && cfg_q.idx >= 64 && cfg_q.idx < 72 |-> fiq_o == src_b0_i[cfg_q.idx[2:0]]); // R6
  AST_OOR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.idx >= 72 |-> !fiq_o); // R7
  AST_DISARMED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.en |-> !fiq_o); // R8
endmodule

bind fiq_route_sel fiq_route_sel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .src_b0_i(src_b0_i),
  .src_b1_i(src_b1_i),
  .src_b2_i(src_b2_i),
  .fiq_o   (fiq_o),
  .cfg_q   (cfg_q)
);

// File: tb/fiq_route_sel_tb_top.sv
`timescale 1ns/1ps
module fiq_route_sel_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  src_b0_i = '0;
  logic [31:0] src_b1_i = '0, src_b2_i = '0;
  logic        fiq_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  fiq_route_sel dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0; wdata_i = '0; addr_i = 8'h0C;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    req_i = 0;
  endtask

  task automatic set_src(input logic [7:0] b0, input logic [31:0] b1, input logic [31:0] b2);
    src_b0_i = b0; src_b1_i = b1; src_b2_i = b2;
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(8'h0C, d);
    chk("R1 reg", d, 32'h0);
    set_src(8'hFF, '1, '1);
    chk("R1 fiq", {31'b0, fiq_o}, 32'h0);
    set_src('0, '0, '0);
  endtask

  task automatic t_regfile();
    logic [31:0] d;
    bus_wr(8'h0C, 32'hFFFF_FF5A);
    bus_rd(8'h0C, d);
    chk("R2 readback", d, 32'h0000_005A);
    bus_wr(8'h0C, 32'h1234_5681);
    bus_rd(8'h0C, d);
    chk("R2 readback2", d, 32'h0000_0081);
  endtask

  task automatic t_other_addr();
    logic [31:0] d;
    bus_wr(8'h08, 32'h0000_00C5);
    bus_wr(8'h0D, 32'h0000_00C5);
    bus_rd(8'h0C, d);
    chk("R3 write ignored", d, 32'h0000_0081);
    bus_rd(8'h08, d);
    chk("R3 read other", d, 32'h0);
    set_src('0, 32'h0000_0002, '0);
    chk("R3 fiq after ignored", {31'b0, fiq_o}, 32'h1);
    set_src('0, '0, '0);
  endtask

  task automatic t_group(input string tag, input int lo, input int n, input int grp);
    for (int i = 0; i < n; i += (n > 8 ? 7 : 1)) begin
      bus_wr(8'h0C, 32'h80 | 32'(lo + i));
      case (grp)
        0: set_src(8'(1) << i, '0, '0);
        1: set_src('0, 32'(1) << i, '0);
        default: set_src('0, '0, 32'(1) << i);
      endcase
      chk(tag, {31'b0, fiq_o}, 32'h1);
      // all other lines high, selected line low: R9
      case (grp)
        0: set_src(~(8'(1) << i), '1, '1);
        1: set_src('1, ~(32'(1) << i), '1);
        default: set_src('1, '1, ~(32'(1) << i));
      endcase
      chk({tag, " R9 others"}, {31'b0, fiq_o}, 32'h0);
    end
    set_src('0, '0, '0);
  endtask

  task automatic t_oor();
    int idx[3] = '{72, 100, 127};
    foreach (idx[k]) begin
      bus_wr(8'h0C, 32'h80 | 32'(idx[k]));
      set_src('1, '1, '1);
      chk("R7 out of range", {31'b0, fiq_o}, 32'h0);
    end
    set_src('0, '0, '0);
  endtask

  task automatic t_disarm();
    bus_wr(8'h0C, 32'h0000_0041);
    set_src('1, '1, '1);
    chk("R8 disarmed", {31'b0, fiq_o}, 32'h0);
    bus_wr(8'h0C, 32'h0000_00C1);
    chk("R8 rearmed", {31'b0, fiq_o}, 32'h1);
    set_src('0, '0, '0);
  endtask

  task automatic t_level();
    bus_wr(8'h0C, 32'h0000_0085);
    @(negedge clk_i);
    set_src('0, 32'h20, '0);
    chk("R9 rise same cycle", {31'b0, fiq_o}, 32'h1);
    set_src('0, 32'h0, '0);
    chk("R9 fall same cycle", {31'b0, fiq_o}, 32'h0);
  endtask

  initial begin
    #1 t_reset();
    #30 rst_ni = 1'b1;
    t_regfile();
    t_other_addr();
    t_group("R4 group1", 0, 32, 1);
    t_group("R5 group2", 32, 32, 2);
    t_group("R6 group0", 64, 8, 0);
    t_oor();
    t_disarm();
    t_level();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule